// File: doc/BRIEF.md
# Polled Character Receive/Transmit Register Block

This peripheral sits on a simple processor address/data bus and gives software polled access to one incoming character from a keyboard source and one outgoing character toward a display sink. Four word-aligned registers sit above a base address. Two are control words that carry a ready flag. The other two are data words that carry an 8-bit character code.

Software polls the receive control word until its flag is set, and then reads the receive data word. That read clears the flag. For output, software polls the transmit control word until its flag is set, and then writes the transmit data word. That write clears the flag. The display side sees a pending character, consumes it, and pulses a take strobe that sets the flag again.

Each direction holds exactly one character, with no queueing. A key that arrives before the previous one was read replaces it.

Top module: `char_io_regs`

## Requirements
- R1: After synchronous reset the receive flag is 0, the transmit flag is 1 (so disp_pending is 0), disp_char is 0x00 and bus_rdata is 0.
- R2: With base 0xFFFF0000, the word offsets map as follows: 0x0 is receive control, 0x4 is receive data, 0x8 is transmit control and 0xC is transmit data. A read presented with bus_rd returns its value on bus_rdata in the following cycle. Each flag is in bit 0 and each character is in bits 7:0. All other bits read as 0.
- R3: bus_rdata is 0 in the cycle after any cycle without bus_rd. It is also 0 after a read of an address that is outside the four words or not word-aligned (address bits 1:0 not zero).
- R4: A kbd_valid cycle stores kbd_char and sets the receive flag. If the flag is already 1, the new character replaces the old one and the flag stays 1.
- R5: A read of receive data returns the held character and clears the receive flag. If kbd_valid occurs in the same cycle, the read returns the old character and the new character is held with the flag set.
- R6: A write of transmit data stores bus_wdata[7:0] and clears the transmit flag. From the next cycle, disp_char shows the byte and disp_pending is 1.
- R7: A disp_take cycle while disp_pending is 1 sets the transmit flag. disp_take while disp_pending is 0 has no effect. When a transmit-data write and disp_take fall in the same cycle, the write wins.
- R8: Writes to receive control, receive data, transmit control, or any unmapped address change no state.
- R9: Reads of either control word change no flag or character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the bus access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| kbd_valid | input | 1 | Keyboard source presents a new character |
| kbd_char | input | 8 | Character code from the keyboard source |
| disp_char | output | 8 | Character held for the display sink |
| disp_pending | output | 1 | High while a character waits for the display |
| disp_take | input | 1 | Display sink has consumed the pending character |

## Verification
A wrong flag becomes visible at the ports within one cycle. Either the next control-word read returns the wrong bit 0, or disp_pending has the wrong level right after the edge that should have changed it. A wrong held character shows up on the next receive-data read, or on disp_char in the cycle after the write. The bench therefore checks every one of the 256 character codes in both directions and reads back the flags around each access. It then covers the same-cycle collisions and the ignored accesses, which would otherwise corrupt state without any immediate symptom.

// File: rtl/cio_pkg.sv
package cio_pkg;
  localparam int NUM_REGS  = 4;
  localparam int BYTES_PER = 4;

  typedef enum logic [1:0] {
    REG_RX_CTRL = 2'd0,
    REG_RX_DATA = 2'd1,
    REG_TX_CTRL = 2'd2,
    REG_TX_DATA = 2'd3
  } cio_reg_e;
endpackage

// File: rtl/cio_decode.sv
module cio_decode #(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       rd,
  input  logic                       wr,
  output logic [cio_pkg::NUM_REGS-1:0] rd_sel,
  output logic [cio_pkg::NUM_REGS-1:0] wr_sel
);
  localparam int LANE_W = $clog2(cio_pkg::BYTES_PER);
  localparam int OFF_W  = $clog2(cio_pkg::NUM_REGS * cio_pkg::BYTES_PER);
  localparam int IDX_W  = OFF_W - LANE_W;

  logic             in_window;
  logic [IDX_W-1:0] idx;

  assign in_window = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]) &&
                     (addr[LANE_W-1:0] == '0);
  assign idx = addr[OFF_W-1:LANE_W];

  for (genvar g = 0; g < cio_pkg::NUM_REGS; g++) begin : g_sel
    assign rd_sel[g] = rd && in_window && (idx == IDX_W'(g));
    assign wr_sel[g] = wr && in_window && (idx == IDX_W'(g));
  end

  always_comb begin
    a_r3_rd_onehot: assert ($onehot0(rd_sel));
    a_r8_wr_onehot: assert ($onehot0(wr_sel));
  end
endmodule

// File: rtl/cio_rx_slot.sv
module cio_rx_slot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_char,
  input  logic              consume,
  output logic              ready,
  output logic [CHAR_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      held  <= '0;
    end else if (load) begin
      held  <= load_char;
      ready <= 1'b1;
    end else if (consume) begin
      ready <= 1'b0;
    end
  end

  a_r4_load_sets: assert property (@(posedge clk) disable iff (rst)
    load |=> (ready && held == $past(load_char)));
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (consume && !load) |=> !ready);
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!load && !consume) |=> ($stable(ready) && $stable(held)));
endmodule

// File: rtl/cio_tx_slot.sv
module cio_tx_slot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              write,
  input  logic [CHAR_W-1:0] write_char,
  input  logic              take,
  output logic              ready,
  output logic [CHAR_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b1;
      held  <= '0;
    end else if (write) begin
      held  <= write_char;
      ready <= 1'b0;
    end else if (take && !ready) begin
      ready <= 1'b1;
    end
  end

  a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
    write |=> (!ready && held == $past(write_char)));
  a_r7_take_sets: assert property (@(posedge clk) disable iff (rst)
    (take && !write) |=> ready);
  a_r8_char_stable: assert property (@(posedge clk) disable iff (rst)
    !write |=> $stable(held));
endmodule

// File: rtl/char_io_regs.sv
module char_io_regs #(
  parameter int                ADDR_W = 32,
  parameter int                DATA_W = 32,
  parameter int                CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_char,
  output logic [CHAR_W-1:0] disp_char,
  output logic              disp_pending,
  input  logic              disp_take
);
  import cio_pkg::*;

  logic [NUM_REGS-1:0] rd_sel;
  logic [NUM_REGS-1:0] wr_sel;
  logic                rx_ready, tx_ready;
  logic [CHAR_W-1:0]   rx_held, tx_held;
  logic [DATA_W-1:0]   rdata_next;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CHAR_W];

  cio_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .addr   (bus_addr),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel)
  );

  cio_rx_slot #(.CHAR_W(CHAR_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .load      (kbd_valid),
    .load_char (kbd_char),
    .consume   (rd_sel[REG_RX_DATA]),
    .ready     (rx_ready),
    .held      (rx_held)
  );

  cio_tx_slot #(.CHAR_W(CHAR_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .write      (wr_sel[REG_TX_DATA]),
    .write_char (bus_wdata[CHAR_W-1:0]),
    .take       (disp_take),
    .ready      (tx_ready),
    .held       (tx_held)
  );

  always_comb begin
    rdata_next = '0;
    unique case (1'b1)
      rd_sel[REG_RX_CTRL]: rdata_next[0]          = rx_ready;
      rd_sel[REG_RX_DATA]: rdata_next[CHAR_W-1:0] = rx_held;
      rd_sel[REG_TX_CTRL]: rdata_next[0]          = tx_ready;
      rd_sel[REG_TX_DATA]: rdata_next[CHAR_W-1:0] = tx_held;
      default:             rdata_next             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rdata_next;
  end

  assign disp_char    = tx_held;
  assign disp_pending = !tx_ready;

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_rdata[DATA_W-1:CHAR_W] == '0));
  a_r7_pending_holds: assert property (@(posedge clk) disable iff (rst)
    (disp_pending && !disp_take) |=> disp_pending);
endmodule

// File: tb/tb_char_io_regs.sv
`timescale 1ns/1ps
module tb_char_io_regs;
  localparam logic [31:0] A_RXC = 32'hFFFF_0000;
  localparam logic [31:0] A_RXD = 32'hFFFF_0004;
  localparam logic [31:0] A_TXC = 32'hFFFF_0008;
  localparam logic [31:0] A_TXD = 32'hFFFF_000C;

  logic        clk = 0, rst = 1;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_rdata;
  logic        kbd_valid = 0;
  logic [7:0]  kbd_char = '0;
  logic [7:0]  disp_char;
  logic        disp_pending;
  logic        disp_take = 0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  char_io_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_valid(kbd_valid),
    .kbd_char(kbd_char), .disp_char(disp_char), .disp_pending(disp_pending),
    .disp_take(disp_take)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk); kbd_char = c; kbd_valid = 1;
    @(negedge clk); kbd_valid = 0;
  endtask

  task automatic take();
    @(negedge clk); disp_take = 1;
    @(negedge clk); disp_take = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 pending", {31'b0, disp_pending}, 32'h0);
    check("R1 disp_char", {24'b0, disp_char}, 32'h0);
    rd(A_RXC, d); check("R1 rx flag", d, 32'h0);
    rd(A_TXC, d); check("R1 tx flag", d, 32'h1);

    // R2 R4 R5 R9: every character through the receive path
    for (int c = 0; c < 256; c++) begin
      key(8'(c));
      rd(A_RXC, d); check("R4 rx flag set", d, 32'h1);
      rd(A_RXC, d); check("R9 ctrl read keeps flag", d, 32'h1);
      rd(A_RXD, d); check("R2 rx data", d, 32'(c));
      rd(A_RXC, d); check("R5 rx flag cleared", d, 32'h0);
    end

    // R2 R6 R7: every character through the transmit path
    for (int c = 0; c < 256; c++) begin
      wr(A_TXD, {24'hA5C3E1, 8'(c)});
      check("R6 disp_char", {24'b0, disp_char}, 32'(c));
      check("R6 pending", {31'b0, disp_pending}, 32'h1);
      rd(A_TXC, d); check("R6 tx flag cleared", d, 32'h0);
      rd(A_TXD, d); check("R2 tx data readback", d, 32'(c));
      take();
      check("R7 take clears pending", {31'b0, disp_pending}, 32'h0);
      rd(A_TXC, d); check("R7 tx flag set", d, 32'h1);
    end

    // R7 take while not pending is ignored
    take();
    check("R7 idle take", {31'b0, disp_pending}, 32'h0);
    rd(A_TXC, d); check("R7 idle take flag", d, 32'h1);

    // R7 write and take in same cycle: write wins
    @(negedge clk); bus_addr = A_TXD; bus_wdata = 32'h5A; bus_wr = 1; disp_take = 1;
    @(negedge clk); bus_wr = 0; disp_take = 0;
    check("R7 collision pending", {31'b0, disp_pending}, 32'h1);
    check("R7 collision char", {24'b0, disp_char}, 32'h5A);
    take();

    // R4 overwrite while ready
    key(8'h41); key(8'h42);
    rd(A_RXC, d); check("R4 overwrite flag", d, 32'h1);
    rd(A_RXD, d); check("R4 overwrite char", d, 32'h42);

    // R5 read and new key in same cycle
    key(8'h10);
    @(negedge clk); bus_addr = A_RXD; bus_rd = 1; kbd_char = 8'h20; kbd_valid = 1;
    @(negedge clk); bus_rd = 0; kbd_valid = 0;
    check("R5 collision old char", bus_rdata, 32'h10);
    rd(A_RXC, d); check("R5 collision flag", d, 32'h1);
    rd(A_RXD, d); check("R5 collision new char", d, 32'h20);

    // R8 ignored writes
    key(8'h77);
    wr(A_RXC, 32'h0); wr(A_RXD, 32'h33); wr(A_TXC, 32'h0);
    wr(32'hFFFF_0010, 32'h99); wr(32'hFFFF_000D, 32'h66); wr(32'hFFFE_000C, 32'h44);
    check("R8 pending", {31'b0, disp_pending}, 32'h0);
    check("R8 disp_char", {24'b0, disp_char}, 32'h5A);
    rd(A_RXC, d); check("R8 rx flag", d, 32'h1);
    rd(A_RXD, d); check("R8 rx char", d, 32'h77);

    // R3 unmapped and misaligned reads, and idle cycle
    key(8'hEE);
    rd(32'hFFFF_0010, d); check("R3 above window", d, 32'h0);
    rd(32'hFFFE_0004, d); check("R3 other base", d, 32'h0);
    for (int b = 1; b < 4; b++) begin
      rd(A_RXD + 32'(b), d); check("R3 misaligned", d, 32'h0);
    end
    rd(A_RXC, d); check("R3 flag after bad reads", d, 32'h1);
    @(negedge clk);
    check("R3 idle rdata", bus_rdata, 32'h0);

    // R1 reset mid-activity
    wr(A_TXD, 32'h12);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 re-reset pending", {31'b0, disp_pending}, 32'h0);
    rd(A_RXC, d); check("R1 re-reset rx flag", d, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule